// File: doc/BRIEF.md
# UART Serial Transmit Engine

This block is the sending half of an asynchronous serial port. Software or a bus bridge writes a character into a one-entry holding register. When the shifter is free, the character moves into it. The shifter then drives the frame onto the serial line: a space start bit, the data bits from the least significant bit upward, an optional parity bit, and one or two mark stop bits. All bit timing comes from a single-cycle enable that pulses at sixteen times the baud rate. The shifter advances one bit for every sixteen of those pulses.

Two config inputs are captured when each frame starts: the character length (five to eight bits) and the parity and stop options. A character written while a frame is on the line waits in the holding register. Its start bit follows the last stop bit of the current frame with no idle time between them. The line rests at mark in four cases: during reset, while the transmitter is disabled, while there is nothing to send, and during loopback. In loopback the frame still runs internally and appears on a separate loopback output, which a receiver can use. The modem clear-to-send input is accepted but has no influence on the transmitter.

Top module: `uart_tx_core`

## Requirements
- R1: A frame is a start bit at 0, then the data bits LSB first, then stop bits at 1. The character length is 5 + `cfg_wlen` bits (`cfg_wlen` 0..3 gives 5..8 bits), and the unused upper bits of `wr_data` are not sent.
- R2: Every bit of a frame, start and stop included, stays on the line for exactly 16 `tick16` pulses. The line changes only on a tick, when a frame starts, or when a frame is aborted.
- R3: With `cfg_par_en` = 1, a parity bit follows the data bits. With `cfg_par_even` = 1 it makes the count of ones in the data plus parity even; with `cfg_par_even` = 0 it makes that count odd.
- R4: `cfg_stop2` = 0 sends one stop bit and `cfg_stop2` = 1 sends two.
- R5: `txd` and `loop_sdata` are 1 while `rst` is high and whenever both the holding register and the shifter are empty.
- R6: While `tx_en` is 0, `txd` is 1. Lowering `tx_en` aborts the frame in progress. A character written while disabled stays in the holding register and is sent once `tx_en` returns to 1.
- R7: While `loop_mode` is 1, `txd` is 1 and the frame is presented on `loop_sdata` instead. Outside loopback and with `tx_en` high, `txd` equals `loop_sdata`.
- R8: `cts_n` has no effect on `txd`, `loop_sdata` or the flags.
- R9: One clock after a `wr_stb` cycle, `hold_empty` is 0. When the shifter is idle and enabled, the character moves into the shifter on the next clock and `hold_empty` returns to 1.
- R10: A character already held when the last stop bit ends starts its start bit on the very next tick period, with no idle bit time in between.
- R11: `all_empty` is 1 only when the holding register is empty and no frame is on the line.
- R12: A write while the holding register is full replaces the held character. Only the newest character is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, asynchronous |
| tick16 | input | 1 | Enable pulse at 16 times the baud rate |
| tx_en | input | 1 | Transmitter enable |
| loop_mode | input | 1 | Loopback select; holds `txd` at mark |
| cts_n | input | 1 | Modem clear-to-send, ignored |
| wr_stb | input | 1 | Write strobe into the holding register |
| wr_data | input | DATA_W (8) | Character to send |
| cfg_wlen | input | 2 | Character length code, 5 + value bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| txd | output | 1 | Serial line, 1 = mark |
| loop_sdata | output | 1 | Internal frame stream for loopback |
| hold_empty | output | 1 | Holding register empty |
| all_empty | output | 1 | Holding register and shifter both empty |

## Verification
Each flag result has a known latency. `hold_empty` falls one clock after the write strobe and rises one clock later when the shifter is free. The line changes only at the clock edge that samples a `tick16` pulse. The bench therefore samples the line on the falling edge just before each tick. It expects exactly sixteen equal samples per bit, and a back-to-back start must show a gap of zero samples. Disable, reset and loopback effects are combinational on `txd`, so they are checked at the first falling edge after the input changes. The flags are checked at the falling edges one and two clocks after a write.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } tx_state_e;
endpackage

// File: rtl/tx_hold.sv
module tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic              full,
   output logic [DATA_W-1:0] data
);
   // a write in the same cycle as a take refills the slot
   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         full <= 1'b0;
         data <= '0;
      end else if (wr_stb) begin
         full <= 1'b1;
         data <= wr_data;
      end else if (take) begin
         full <= 1'b0;
      end
   end
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
   parameter int TICKS_PER_BIT = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic tick,
   output logic bit_done
);
   localparam int CNT_W = $clog2(TICKS_PER_BIT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

   logic [CNT_W-1:0] cnt;

   assign bit_done = tick && (cnt == LAST);

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt <= '0;
      end else if (clr || bit_done) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/tx_frame.sv
module tx_frame
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int MIN_W  = 5,
   parameter int WLEN_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tx_en,
   input  logic              bit_done,
   input  logic              hold_full,
   input  logic [DATA_W-1:0] hold_data,
   input  logic [WLEN_W-1:0] cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_even,
   input  logic              cfg_stop2,
   output logic              take,
   output logic              tmr_clr,
   output logic              busy,
   output logic              line_bit
);
   localparam int IDX_W = $clog2(DATA_W);

   tx_state_e         state;
   logic [DATA_W-1:0] shreg;
   logic [IDX_W-1:0]  idx;
   logic [IDX_W-1:0]  last_idx;
   logic              par_on;
   logic              par_bit;
   logic              stop_more;

   logic [IDX_W-1:0]  last_idx_in;
   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] masked;
   logic              start_ok;

   assign last_idx_in = IDX_W'(MIN_W - 1) + IDX_W'(cfg_wlen);

   // per-bit length mask, one comparator per data bit position
   for (genvar i = 0; i < DATA_W; i++) begin : g_keep
      assign keep[i] = (IDX_W'(i) <= last_idx_in);
   end

   assign masked   = hold_data & keep;
   assign start_ok = tx_en && hold_full;
   assign take     = start_ok &&
                     ((state == ST_IDLE) ||
                      (state == ST_STOP && bit_done && !stop_more));
   assign tmr_clr  = take || !tx_en || (state == ST_IDLE);
   assign busy     = (state != ST_IDLE);

   always_comb begin
      case (state)
         ST_START: line_bit = 1'b0;
         ST_DATA:  line_bit = shreg[0];
         ST_PAR:   line_bit = par_bit;
         default:  line_bit = 1'b1;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         state     <= ST_IDLE;
         shreg     <= '0;
         idx       <= '0;
         last_idx  <= '0;
         par_on    <= 1'b0;
         par_bit   <= 1'b0;
         stop_more <= 1'b0;
      end else if (!tx_en) begin
         state     <= ST_IDLE;
         stop_more <= 1'b0;
      end else if (take) begin
         state     <= ST_START;
         shreg     <= masked;
         idx       <= '0;
         last_idx  <= last_idx_in;
         par_on    <= cfg_par_en;
         par_bit   <= cfg_par_even ? (^masked) : ~(^masked);
         stop_more <= cfg_stop2;
      end else if (bit_done) begin
         case (state)
            ST_START: begin
               state <= ST_DATA;
               idx   <= '0;
            end
            ST_DATA: begin
               shreg <= shreg >> 1;
               if (idx == last_idx) begin
                  state <= par_on ? ST_PAR : ST_STOP;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            ST_PAR:  state <= ST_STOP;
            ST_STOP: begin
               if (stop_more) stop_more <= 1'b0;
               else           state     <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
   parameter int DATA_W        = 8,
   parameter int MIN_W         = 5,
   parameter int TICKS_PER_BIT = 16,
   localparam int WLEN_W       = $clog2(DATA_W - MIN_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick16,
   input  logic              tx_en,
   input  logic              loop_mode,
   input  logic              cts_n,
   input  logic              wr_stb,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [WLEN_W-1:0] cfg_wlen,
   input  logic              cfg_par_en,
   input  logic              cfg_par_even,
   input  logic              cfg_stop2,
   output logic              txd,
   output logic              loop_sdata,
   output logic              hold_empty,
   output logic              all_empty
);
   if (TICKS_PER_BIT < 2) begin : g_bad_ticks
      $error("TICKS_PER_BIT must be at least 2");
   end
   if (MIN_W < 1 || MIN_W >= DATA_W) begin : g_bad_width
      $error("MIN_W must lie in 1 .. DATA_W-1");
   end

   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic              take;
   logic              tmr_clr;
   logic              bit_done;
   logic              frm_busy;
   logic              line_bit;

   tx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst     (rst),
      .wr_stb  (wr_stb),
      .wr_data (wr_data),
      .take    (take),
      .full    (hold_full),
      .data    (hold_data)
   );

   tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .clr      (tmr_clr),
      .tick     (tick16),
      .bit_done (bit_done)
   );

   tx_frame #(.DATA_W(DATA_W), .MIN_W(MIN_W), .WLEN_W(WLEN_W)) u_frame (
      .clk          (clk),
      .rst          (rst),
      .tx_en        (tx_en),
      .bit_done     (bit_done),
      .hold_full    (hold_full),
      .hold_data    (hold_data),
      .cfg_wlen     (cfg_wlen),
      .cfg_par_en   (cfg_par_en),
      .cfg_par_even (cfg_par_even),
      .cfg_stop2    (cfg_stop2),
      .take         (take),
      .tmr_clr      (tmr_clr),
      .busy         (frm_busy),
      .line_bit     (line_bit)
   );

   assign loop_sdata = frm_busy ? line_bit : 1'b1;
   assign txd        = (loop_mode || !tx_en || !frm_busy) ? 1'b1 : line_bit;
   assign hold_empty = !hold_full;
   assign all_empty  = !hold_full && !frm_busy;
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
   input logic clk,
   input logic rst,
   input logic tick16,
   input logic tx_en,
   input logic loop_mode,
   input logic cts_n,
   input logic wr_stb,
   input logic txd,
   input logic loop_sdata,
   input logic hold_empty,
   input logic all_empty,
   input logic busy
);
   // R5
   idle_mark_chk: assert property (@(posedge clk) disable iff (rst)
      all_empty |-> (txd && loop_sdata));

   // R6
   dis_mark_chk: assert property (@(posedge clk) disable iff (rst)
      !tx_en |-> txd);

   // R7
   loop_mark_chk: assert property (@(posedge clk) disable iff (rst)
      loop_mode |-> txd);

   // R9
   wr_fill_chk: assert property (@(posedge clk) disable iff (rst)
      wr_stb |=> !hold_empty);

   // R11
   all_empty_chk: assert property (@(posedge clk) disable iff (rst)
      all_empty |-> (hold_empty && !busy));

   // R2
   tick_step_chk: assert property (@(posedge clk) disable iff (rst)
      (!$stable(loop_sdata) && $past(busy) && busy && $past(tx_en)) |-> $past(tick16));

   // R8
   cts_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (!$stable(cts_n) && all_empty) |-> txd);
endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .tick16     (tick16),
   .tx_en      (tx_en),
   .loop_mode  (loop_mode),
   .cts_n      (cts_n),
   .wr_stb     (wr_stb),
   .txd        (txd),
   .loop_sdata (loop_sdata),
   .hold_empty (hold_empty),
   .all_empty  (all_empty),
   .busy       (frm_busy)
);

// File: tb/sim_uart_tx_core.sv
`timescale 1ns/1ps
module sim_uart_tx_core;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick16 = 1'b0;
   logic       tx_en = 1'b0;
   logic       loop_mode = 1'b0;
   logic       cts_n = 1'b1;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_data = '0;
   logic [1:0] cfg_wlen = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b0;
   logic       cfg_stop2 = 1'b0;
   wire        txd, loop_sdata, hold_empty, all_empty;

   int compared = 0;
   int mismatched = 0;

   uart_tx_core u0 (
      .clk(clk), .rst(rst), .tick16(tick16), .tx_en(tx_en),
      .loop_mode(loop_mode), .cts_n(cts_n), .wr_stb(wr_stb),
      .wr_data(wr_data), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
      .cfg_par_even(cfg_par_even), .cfg_stop2(cfg_stop2), .txd(txd),
      .loop_sdata(loop_sdata), .hold_empty(hold_empty), .all_empty(all_empty)
   );

   always #10 clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic void build(input logic [7:0] d, input logic [1:0] wl,
                                 input logic pe, input logic pev, input logic s2,
                                 output logic [11:0] bits, output int len);
      int  n = 5 + int'(wl);
      logic p = 1'b0;
      bits = '0;
      for (int i = 0; i < n; i++) begin
         bits[1+i] = d[i];
         p ^= d[i];
      end
      len = 1 + n;
      if (pe) begin
         bits[len] = pev ? p : ~p;
         len++;
      end
      bits[len] = 1'b1;
      len++;
      if (s2) begin
         bits[len] = 1'b1;
         len++;
      end
   endfunction

   // tick every third clock, random cts_n every clock (R8 stimulus)
   initial begin
      int tcnt = 0;
      void'($urandom(32'd7321));
      forever begin
         @(posedge clk);
         #1;
         tcnt   = (tcnt + 1) % 3;
         tick16 = (tcnt == 0);
         cts_n  = 1'($urandom % 2);
      end
   end

   // frame monitor: samples loop_sdata on the falling edge before each tick
   logic [11:0] q_bits[$];
   int          q_len[$];
   bit          mon_on = 1'b1;
   bit          in_frame = 1'b0;
   logic [11:0] cur_bits;
   int          cur_len, idx, ferr;
   int          gap = 1000;
   int          last_gap = 1000;

   always @(negedge clk) begin
      if (!rst) begin
         // R6 R7 R8: line level follows enable and loopback only
         check("R7 txd level", txd, (loop_mode || !tx_en) ? 1'b1 : loop_sdata);
         if (all_empty) check("R5 idle mark", {txd, loop_sdata}, 2'b11);
         if (!mon_on) begin
            in_frame = 1'b0;
         end else if (tick16) begin
            if (!in_frame) begin
               if (loop_sdata == 1'b0) begin
                  if (q_len.size() == 0) begin
                     check("R1 unexpected start bit", 1, 0);
                  end else begin
                     cur_bits = q_bits.pop_front();
                     cur_len  = q_len.pop_front();
                     in_frame = 1'b1;
                     idx = 0;
                     ferr = 0;
                     last_gap = gap;
                     gap = 0;
                  end
               end else begin
                  gap++;
               end
            end
            if (in_frame) begin
               if (loop_sdata !== cur_bits[idx/16]) ferr++;
               idx++;
               if (idx == 16 * cur_len) begin
                  // R1 R2 R3 R4: every sample of every bit matched
                  check("R1/R2/R3/R4 frame sample errors", ferr, 0);
                  in_frame = 1'b0;
               end
            end
         end
      end
   end

   task automatic wr_raw(input logic [7:0] d);
      @(negedge clk);
      wr_stb  = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic expect_frame(input logic [7:0] d);
      logic [11:0] b;
      int l;
      build(d, cfg_wlen, cfg_par_en, cfg_par_even, cfg_stop2, b, l);
      q_bits.push_back(b);
      q_len.push_back(l);
   endtask

   task automatic send(input logic [7:0] d);
      while (!hold_empty) @(negedge clk);
      expect_frame(d);
      wr_raw(d);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!all_empty);
      repeat (8) @(negedge clk);
   endtask

   // watchdog
   initial begin
      #(20 * 190000);
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R5 reset state
      check("R5 reset txd", txd, 1'b1);
      check("R5 reset loop_sdata", loop_sdata, 1'b1);
      check("R9 reset hold_empty", hold_empty, 1'b1);
      check("R11 reset all_empty", all_empty, 1'b1);
      rst = 1'b0;
      tx_en = 1'b1;
      repeat (4) @(negedge clk);

      // R9 R11 flag timing, 8N1
      expect_frame(8'hA5);
      @(negedge clk);
      wr_stb = 1'b1; wr_data = 8'hA5;
      @(negedge clk);
      wr_stb = 1'b0;
      check("R9 hold_empty after write", hold_empty, 1'b0);
      check("R11 all_empty after write", all_empty, 1'b0);
      @(negedge clk);
      check("R9 hold_empty after load", hold_empty, 1'b1);
      check("R11 all_empty while shifting", all_empty, 1'b0);
      wait_idle();

      // R10 back to back, 7E2
      cfg_wlen = 2'd2; cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_stop2 = 1'b1;
      send(8'h3C);
      send(8'hC3);
      wait_idle();
      check("R10 idle samples between frames", last_gap, 0);

      // R12 overwrite while disabled
      tx_en = 1'b0;
      cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_stop2 = 1'b0;
      wr_raw(8'h11);
      wr_raw(8'h96);
      repeat (60) @(negedge clk);
      check("R6 held while disabled", hold_empty, 1'b0);
      check("R6 txd mark while disabled", txd, 1'b1);
      expect_frame(8'h96);
      tx_en = 1'b1;
      wait_idle();
      check("R12 only newest sent", q_len.size(), 0);

      // R6 abort mid frame
      mon_on = 1'b0;
      wr_raw(8'h00);
      repeat (70) @(negedge clk);
      tx_en = 1'b0;
      @(negedge clk);
      check("R6 abort txd", txd, 1'b1);
      check("R6 abort loop_sdata", loop_sdata, 1'b1);
      check("R6 abort all_empty", all_empty, 1'b1);
      cfg_wlen = 2'd0; cfg_par_en = 1'b1; cfg_par_even = 1'b0;
      wr_raw(8'h1B);
      repeat (30) @(negedge clk);
      mon_on = 1'b1;
      expect_frame(8'h1B);
      tx_en = 1'b1;
      wait_idle();

      // R5 reset mid frame
      mon_on = 1'b0;
      wr_raw(8'h0F);
      repeat (50) @(negedge clk);
      rst = 1'b1;
      #1;
      check("R5 reset mid frame txd", txd, 1'b1);
      check("R5 reset mid frame flags", {hold_empty, all_empty}, 2'b11);
      @(negedge clk);
      rst = 1'b0;
      mon_on = 1'b1;
      repeat (10) @(negedge clk);

      // R7 loopback: frame on loop_sdata, txd at mark
      loop_mode = 1'b1;
      cfg_wlen = 2'd1; cfg_par_en = 1'b1; cfg_par_even = 1'b1; cfg_stop2 = 1'b0;
      send(8'h2D);
      send(8'h12);
      wait_idle();
      loop_mode = 1'b0;

      // random formats and characters (R1 R3 R4)
      for (int it = 0; it < 24; it++) begin
         cfg_wlen     = 2'($urandom % 4);
         cfg_par_en   = 1'($urandom % 2);
         cfg_par_even = 1'($urandom % 2);
         cfg_stop2    = 1'($urandom % 2);
         loop_mode    = (($urandom % 5) == 0);
         for (int k = 0; k < 1 + int'($urandom % 3); k++) begin
            send(8'($urandom));
         end
         wait_idle();
      end

      check("R1 all expected frames seen", q_len.size(), 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule